// File: doc/BRIEF.md
# Scanline Buffer Pixel Writer

This block builds one display line at a time in a 512-entry buffer of 5-bit colour indices. Upstream logic presents graphics bytes one per cycle. Each byte comes with a 3-bit palette number, a draw mode and a fill-zero control. The first byte of an object also carries an 8-bit start position. The writer expands each byte into up to eight buffer writes in a single cycle, and the write position then advances past the pixels it covered.

The buffer has two banks. When `line_swap` is pulsed, the bank that has just been written becomes the scan bank. The scan bank is read from entry 0 upwards, and each index is turned into an 8-bit colour through a 32-entry colour register file. Every entry is cleared as it is read. During the scan, the other bank keeps accepting writes for the next line. A one-cycle `clr_done` pulse marks the end of the scan.

The colour register file is written through a 6-bit address port. Only addresses with bit 5 set reach a register: register number = address bits 4..0.

Top module: `line_pixel_writer`

## Requirements
- R1: After reset, `pix_valid` and `clr_done` are low, both banks hold index 0 and every colour register holds 0.
- R2: Mode 0 (wide, 4 pixels per byte): the byte is read as four 2-bit fields, bits 7..6 first. A non-zero field c writes index {pal, c} to two neighbouring entries, and each field moves the position on by 2.
- R3: Mode 1 (split, 2 pixels per byte): bits 7..6 and 5..4 are the colours c. The first pixel writes {pal[2], bits 3..2, c} and the second writes {pal[2], bits 1..0, c}. Each pixel covers two entries.
- R4: Mode 2 (fine, 8 pixels per byte): every set bit, bit 7 first, writes index {pal, 2'b10} to one entry.
- R5: Mode 3 (fine, 4 pixels per byte): bits 7..4 enable one entry each. The entries enabled by bits 7..6 take index {pal[2], bits 3..2, 2'b10}, and those enabled by bits 5..4 take {pal[2], bits 1..0, 2'b10}.
- R6: With `obj_fill_zero` low, a zero pixel leaves the entry it covers unchanged, so earlier objects show through.
- R7: With `obj_fill_zero` high, a zero pixel writes index 0 to the entries it covers.
- R8: A byte presented with `obj_skip` writes nothing. It advances the position by 8 in modes 0 and 2, and by 4 in modes 1 and 3, which is the same advance an unskipped byte gives.
- R9: The position for `obj_first` is twice `obj_start`. All buffer positions wrap modulo 512.
- R10: On scan-out, an index whose low two bits are 0 yields colour register 0 (the background). Any other index k yields colour register k.
- R11: After a swap, exactly VIS_W pixels come out, in entry order from 0. `clr_done` then pulses once, after all 512 entries of the scanned bank have been cleared to 0.
- R12: A colour register write whose address has bit 5 clear changes no register.
- R13: Bytes written while a line is being scanned go to the other bank. They do not change the pixels of the line being scanned, and they appear on the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obj_wr | input | 1 | A graphics byte is presented this cycle |
| obj_first | input | 1 | First byte of an object; load position from obj_start |
| obj_skip | input | 1 | Advance position only, no writes |
| obj_byte | input | 8 | Graphics byte |
| obj_pal | input | 3 | Palette number |
| obj_start | input | 8 | Start position (in units of two entries) |
| obj_mode | input | 2 | Draw mode 0..3 |
| obj_fill_zero | input | 1 | Zero pixels write index 0 |
| cfg_we | input | 1 | Colour register write strobe |
| cfg_addr | input | 6 | Colour register address |
| cfg_wdata | input | 8 | Colour register data |
| line_swap | input | 1 | Swap banks and start scan-out |
| pix_valid | output | 1 | pix_color holds a visible pixel |
| pix_color | output | 8 | Pixel colour |
| clr_done | output | 1 | Scan and clear of the line finished |

## Verification
The assertions assume that `line_swap` is never raised while a scan is still running. The stimulus keeps to this by issuing a swap only after the previous `clr_done` has been seen. They also assume that a skipped byte never produces buffer writes and that opaque pixels always carry a non-zero colour field. These two are checked against `obj_skip` and `obj_fill_zero` as the bench drives them. Every object starts with `obj_first`, so the bench's expected positions never depend on leftover position state from an earlier test.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
    localparam int SLOTS = 8;
    localparam int PAL_W = 3;
    localparam int IDX_W = PAL_W + 2;

    typedef enum logic [1:0] {
        MODE_WIDE4  = 2'd0,
        MODE_SPLIT2 = 2'd1,
        MODE_FINE8  = 2'd2,
        MODE_FINE4  = 2'd3
    } draw_mode_e;
endpackage

// File: rtl/lpw_pixel_decode.sv
module lpw_pixel_decode
    import lpw_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic [7:0]                  data,
    input  logic [PAL_W-1:0]            pal,
    input  draw_mode_e                  mode,
    input  logic                        fill_zero,
    input  logic                        skip,
    input  logic [AW-1:0]               base,
    output logic [SLOTS-1:0]            slot_en,
    output logic [SLOTS-1:0][AW-1:0]    slot_addr,
    output logic [SLOTS-1:0][IDX_W-1:0] slot_val,
    output logic [AW-1:0]               advance
);
    logic [1:0] fld;
    logic [1:0] sub;

    always_comb begin
        fld     = '0;
        sub     = '0;
        advance = '0;
        for (int k = 0; k < SLOTS; k++) begin
            slot_en[k]   = 1'b0;
            slot_addr[k] = base + AW'(k);
            slot_val[k]  = '0;
        end
        case (mode)
            MODE_WIDE4: begin
                advance = AW'(8);
                for (int f = 0; f < 4; f++) begin
                    fld = data[7-2*f -: 2];
                    for (int h = 0; h < 2; h++) begin
                        slot_en[2*f+h]  = (fld != 2'd0) || fill_zero;
                        slot_val[2*f+h] = (fld != 2'd0) ? {pal, fld} : '0;
                    end
                end
            end
            MODE_SPLIT2: begin
                advance = AW'(4);
                for (int f = 0; f < 2; f++) begin
                    fld = data[7-2*f -: 2];
                    sub = (f == 0) ? data[3:2] : data[1:0];
                    for (int h = 0; h < 2; h++) begin
                        slot_en[2*f+h]  = (fld != 2'd0) || fill_zero;
                        slot_val[2*f+h] = (fld != 2'd0) ? {pal[PAL_W-1], sub, fld} : '0;
                    end
                end
            end
            MODE_FINE8: begin
                advance = AW'(8);
                for (int k = 0; k < 8; k++) begin
                    slot_en[k]  = data[7-k] || fill_zero;
                    slot_val[k] = data[7-k] ? {pal, 2'b10} : '0;
                end
            end
            default: begin
                advance = AW'(4);
                for (int k = 0; k < 4; k++) begin
                    sub         = (k < 2) ? data[3:2] : data[1:0];
                    slot_en[k]  = data[7-k] || fill_zero;
                    slot_val[k] = data[7-k] ? {pal[PAL_W-1], sub, 2'b10} : '0;
                end
            end
        endcase
        if (skip) begin
            slot_en = '0;
        end
    end
endmodule

// File: rtl/lpw_line_bank.sv
module lpw_line_bank
    import lpw_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_bank,
    input  logic [SLOTS-1:0]            slot_en,
    input  logic [SLOTS-1:0][AW-1:0]    slot_addr,
    input  logic [SLOTS-1:0][IDX_W-1:0] slot_val,
    input  logic                        clr_en,
    input  logic [AW-1:0]               rd_idx,
    output logic [IDX_W-1:0]            rd_val
);
    logic [IDX_W-1:0] mem [2][DEPTH];
    logic             rd_bank;

    assign rd_bank = ~wr_bank;
    assign rd_val  = mem[rd_bank][rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[b][i] <= '0;
                end
            end
        end else begin
            for (int k = 0; k < SLOTS; k++) begin
                if (slot_en[k]) begin
                    mem[wr_bank][slot_addr[k]] <= slot_val[k];
                end
            end
            if (clr_en) begin
                mem[rd_bank][rd_idx] <= '0;
            end
        end
    end

    // R11: an entry read out is empty on the following cycle
    assert_cleared_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (mem[$past(rd_bank)][$past(rd_idx)] == '0));
endmodule

// File: rtl/lpw_palette.sv
module lpw_palette
    import lpw_pkg::*;
#(
    parameter int REG_AW  = 6,
    parameter int COLOR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [REG_AW-1:0]  cfg_addr,
    input  logic [COLOR_W-1:0] cfg_wdata,
    input  logic [IDX_W-1:0]   idx,
    output logic [COLOR_W-1:0] color
);
    localparam int NREG = 2 ** (REG_AW - 1);

    logic [NREG-1:0][COLOR_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (cfg_we && cfg_addr[REG_AW-1]) begin
            regs_q[cfg_addr[REG_AW-2:0]] <= cfg_wdata;
        end
    end

    always_comb begin
        if (idx[1:0] == 2'd0) color = regs_q[0];
        else                  color = regs_q[idx];
    end

    // R12: lower half of the address space reaches no register
    assert_low_half_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_addr[REG_AW-1]) |=> $stable(regs_q));
endmodule

// File: rtl/line_pixel_writer.sv
module line_pixel_writer
    import lpw_pkg::*;
#(
    parameter int BUF_DEPTH = 512,
    parameter int VIS_W     = 320,
    parameter int COLOR_W   = 8,
    parameter int REG_AW    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               obj_wr,
    input  logic               obj_first,
    input  logic               obj_skip,
    input  logic [7:0]         obj_byte,
    input  logic [PAL_W-1:0]   obj_pal,
    input  logic [7:0]         obj_start,
    input  logic [1:0]         obj_mode,
    input  logic               obj_fill_zero,
    input  logic               cfg_we,
    input  logic [REG_AW-1:0]  cfg_addr,
    input  logic [COLOR_W-1:0] cfg_wdata,
    input  logic               line_swap,
    output logic               pix_valid,
    output logic [COLOR_W-1:0] pix_color,
    output logic               clr_done
);
    localparam int AW = $clog2(BUF_DEPTH);

    typedef struct packed {
        logic               wb;
        logic               busy;
        logic [AW-1:0]      idx;
        logic [AW-1:0]      pos;
        logic               pv;
        logic [COLOR_W-1:0] pc;
        logic               done;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [AW-1:0]               base;
    logic [AW-1:0]               advance;
    logic [SLOTS-1:0]            slot_en_raw;
    logic [SLOTS-1:0]            slot_en;
    logic [SLOTS-1:0][AW-1:0]    slot_addr;
    logic [SLOTS-1:0][IDX_W-1:0] slot_val;
    logic [IDX_W-1:0]            rd_val;
    logic [COLOR_W-1:0]          look_color;

    assign base    = (obj_wr && obj_first) ? {obj_start[AW-2:0], 1'b0} : s_q.pos;
    assign slot_en = obj_wr ? slot_en_raw : '0;

    lpw_pixel_decode #(.AW(AW)) decode_i (
        .data      (obj_byte),
        .pal       (obj_pal),
        .mode      (draw_mode_e'(obj_mode)),
        .fill_zero (obj_fill_zero),
        .skip      (obj_skip),
        .base      (base),
        .slot_en   (slot_en_raw),
        .slot_addr (slot_addr),
        .slot_val  (slot_val),
        .advance   (advance)
    );

    lpw_line_bank #(.DEPTH(BUF_DEPTH), .AW(AW)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_bank   (s_q.wb),
        .slot_en   (slot_en),
        .slot_addr (slot_addr),
        .slot_val  (slot_val),
        .clr_en    (s_q.busy),
        .rd_idx    (s_q.idx),
        .rd_val    (rd_val)
    );

    lpw_palette #(.REG_AW(REG_AW), .COLOR_W(COLOR_W)) palette_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .idx       (rd_val),
        .color     (look_color)
    );

    always_comb begin
        s_d      = s_q;
        s_d.pv   = 1'b0;
        s_d.done = 1'b0;
        if (obj_wr) begin
            s_d.pos = base + advance;
        end
        if (s_q.busy) begin
            s_d.pv  = (int'(s_q.idx) < VIS_W);
            s_d.pc  = look_color;
            s_d.idx = s_q.idx + AW'(1);
            if (s_q.idx == AW'(BUF_DEPTH - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else if (line_swap) begin
            s_d.wb   = ~s_q.wb;
            s_d.busy = 1'b1;
            s_d.idx  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pix_valid = s_q.pv;
    assign pix_color = s_q.pc;
    assign clr_done  = s_q.done;

    // R13: a swap is only offered once the previous scan has ended
    assert_swap_when_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        line_swap |-> !s_q.busy);
    // R11: the end-of-line pulse lasts one cycle
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done |=> !clr_done);
    // R11: the last visible pixel precedes the end pulse
    assert_no_pix_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !clr_done);
    // R8: a skipped byte reaches no buffer entry
    assert_skip_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (obj_wr && obj_skip) |-> (slot_en == '0));

    for (genvar k = 0; k < SLOTS; k++) begin : g_opaque
        // R6: without fill-zero every write carries a non-zero colour field
        assert_opaque_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_en[k] && !obj_fill_zero) |-> (slot_val[k][1:0] != 2'd0));
    end
endmodule

// File: tb/line_pixel_writer_tb.sv
module line_pixel_writer_tb_top;
    localparam int DEPTH = 512;
    localparam int VIS   = 320;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       obj_wr = 0, obj_first = 0, obj_skip = 0, obj_fill_zero = 0;
    logic [7:0] obj_byte = 0, obj_start = 0;
    logic [2:0] obj_pal = 0;
    logic [1:0] obj_mode = 0;
    logic       cfg_we = 0;
    logic [5:0] cfg_addr = 0;
    logic [7:0] cfg_wdata = 0;
    logic       line_swap = 0;
    logic       pix_valid, clr_done;
    logic [7:0] pix_color;

    always #5 clk = ~clk;

    line_pixel_writer dut_i (
        .clk(clk), .rst_n(rst_n), .obj_wr(obj_wr), .obj_first(obj_first),
        .obj_skip(obj_skip), .obj_byte(obj_byte), .obj_pal(obj_pal),
        .obj_start(obj_start), .obj_mode(obj_mode), .obj_fill_zero(obj_fill_zero),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .line_swap(line_swap), .pix_valid(pix_valid), .pix_color(pix_color),
        .clr_done(clr_done)
    );

    int n_total = 0;
    int n_pass  = 0;

    logic [4:0] mline [DEPTH];
    logic [4:0] sexp  [DEPTH];
    logic [8:0] mpos;
    logic [7:0] mpal  [32];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    function automatic logic [7:0] ecol(input logic [4:0] e);
        return (e[1:0] == 2'd0) ? mpal[0] : mpal[e];
    endfunction

    task automatic cfg(input logic [5:0] a, input logic [7:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        if (a[5]) mpal[a[4:0]] = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // drives one byte for one cycle and updates the expected line
    task automatic put(input logic [7:0] d, input logic [2:0] pal, input logic [1:0] mode,
                       input bit first, input logic [7:0] start, input bit fz, input bit skip);
        logic [8:0] b, p;
        logic [1:0] c, s;
        obj_wr = 1; obj_byte = d; obj_pal = pal; obj_mode = mode; obj_first = first;
        obj_start = start; obj_fill_zero = fz; obj_skip = skip;
        b = first ? {start, 1'b0} : mpos;
        if (!skip) begin
            case (mode)
                2'd0: for (int f = 0; f < 4; f++) begin
                    c = d[7-2*f -: 2];
                    for (int h = 0; h < 2; h++) begin
                        p = b + 9'(2*f+h);
                        if (c != 0) mline[p] = {pal, c}; else if (fz) mline[p] = 0;
                    end
                end
                2'd1: for (int f = 0; f < 2; f++) begin
                    c = d[7-2*f -: 2];
                    s = (f == 0) ? d[3:2] : d[1:0];
                    for (int h = 0; h < 2; h++) begin
                        p = b + 9'(2*f+h);
                        if (c != 0) mline[p] = {pal[2], s, c}; else if (fz) mline[p] = 0;
                    end
                end
                2'd2: for (int k = 0; k < 8; k++) begin
                    p = b + 9'(k);
                    if (d[7-k]) mline[p] = {pal, 2'b10}; else if (fz) mline[p] = 0;
                end
                default: for (int k = 0; k < 4; k++) begin
                    p = b + 9'(k);
                    s = (k < 2) ? d[3:2] : d[1:0];
                    if (d[7-k]) mline[p] = {pal[2], s, 2'b10}; else if (fz) mline[p] = 0;
                end
            endcase
        end
        mpos = b + ((mode == 2'd0 || mode == 2'd2) ? 9'd8 : 9'd4);
        @(negedge clk);
        obj_wr = 0; obj_first = 0; obj_skip = 0; obj_fill_zero = 0;
    endtask

    task automatic scan_line(input string req);
        int cnt = 0, bad = 0, bad_i = -1, bad_a = 0, bad_e = 0;
        bit seen_done = 0;
        line_swap = 1;
        for (int i = 0; i < DEPTH; i++) begin
            sexp[i] = mline[i];
            mline[i] = 0;
        end
        @(negedge clk);
        line_swap = 0;
        while (!seen_done) begin
            @(negedge clk);
            if (pix_valid) begin
                if (cnt < VIS && pix_color != ecol(sexp[cnt])) begin
                    bad++;
                    if (bad_i < 0) begin
                        bad_i = cnt; bad_a = pix_color; bad_e = ecol(sexp[cnt]);
                    end
                end
                cnt++;
            end
            if (clr_done) seen_done = 1;
        end
        chk(bad == 0, req, $sformatf("pixel %0d colour", bad_i), bad_a, bad_e);
        chk(cnt == VIS, req, "pixel count", cnt, VIS);
        @(negedge clk);
        chk(clr_done == 0, "R11", "done pulse width", clr_done, 0);
    endtask

    task automatic t_reset();
        chk(pix_valid == 0 && clr_done == 0, "R1", "outputs after reset",
            {pix_valid, clr_done}, 0);
        scan_line("R1");
    endtask

    task automatic t_init_palette();
        for (int i = 0; i < 32; i++) cfg(6'(32 + i), 8'(8'h40 + i));
    endtask

    task automatic t_wide4();
        put(8'b11_00_01_10, 3'd3, 2'd0, 1, 8'd10, 0, 0);
        put(8'hE4, 3'd3, 2'd0, 0, 8'd0, 0, 0);
        put(8'h1B, 3'd6, 2'd0, 1, 8'd100, 0, 0);
        scan_line("R2");
    endtask

    task automatic t_split2();
        put(8'b10_01_11_00, 3'd5, 2'd1, 1, 8'd20, 0, 0);
        put(8'hC6, 3'd2, 2'd1, 0, 8'd0, 0, 0);
        put(8'h7F, 3'd7, 2'd1, 1, 8'd70, 0, 0);
        scan_line("R3");
    endtask

    task automatic t_fine8();
        put(8'hA5, 3'd6, 2'd2, 1, 8'd40, 0, 0);
        put(8'h0F, 3'd1, 2'd2, 0, 8'd0, 0, 0);
        scan_line("R4");
    endtask

    task automatic t_fine4();
        put(8'hB6, 3'd4, 2'd3, 1, 8'd60, 0, 0);
        put(8'h79, 3'd1, 2'd3, 0, 8'd0, 0, 0);
        put(8'hF0, 3'd7, 2'd3, 0, 8'd0, 0, 0);
        scan_line("R5");
    endtask

    task automatic t_transparent();
        put(8'hFF, 3'd7, 2'd0, 1, 8'd5, 0, 0);
        put(8'h33, 3'd2, 2'd0, 1, 8'd5, 0, 0);
        put(8'hFF, 3'd5, 2'd2, 1, 8'd30, 0, 0);
        put(8'h81, 3'd1, 2'd2, 1, 8'd30, 0, 0);
        put(8'hFF, 3'd3, 2'd3, 1, 8'd50, 0, 0);
        put(8'h40, 3'd4, 2'd3, 1, 8'd50, 0, 0);
        scan_line("R6");
    endtask

    task automatic t_override();
        put(8'hFF, 3'd7, 2'd0, 1, 8'd5, 0, 0);
        put(8'h33, 3'd2, 2'd0, 1, 8'd5, 1, 0);
        put(8'hFF, 3'd5, 2'd2, 1, 8'd30, 0, 0);
        put(8'h81, 3'd1, 2'd2, 1, 8'd30, 1, 0);
        put(8'hFF, 3'd3, 2'd1, 1, 8'd50, 0, 0);
        put(8'h4E, 3'd4, 2'd1, 1, 8'd50, 1, 0);
        scan_line("R7");
    endtask

    task automatic t_skip();
        put(8'hFF, 3'd1, 2'd0, 1, 8'd2, 0, 0);
        put(8'hFF, 3'd1, 2'd0, 0, 8'd0, 0, 1);
        put(8'h55, 3'd2, 2'd0, 0, 8'd0, 0, 0);
        put(8'hFF, 3'd2, 2'd2, 1, 8'd20, 0, 1);
        put(8'hC3, 3'd2, 2'd2, 0, 8'd0, 0, 0);
        put(8'hAF, 3'd5, 2'd1, 1, 8'd40, 0, 1);
        put(8'hAF, 3'd5, 2'd1, 0, 8'd0, 0, 0);
        put(8'hF5, 3'd6, 2'd3, 1, 8'd60, 0, 1);
        put(8'hF5, 3'd6, 2'd3, 0, 8'd0, 0, 0);
        scan_line("R8");
    endtask

    task automatic t_wrap();
        put(8'hFF, 3'd1, 2'd0, 1, 8'd254, 0, 0);
        put(8'h99, 3'd2, 2'd0, 0, 8'd0, 0, 0);
        put(8'hFF, 3'd3, 2'd2, 1, 8'd255, 0, 0);
        scan_line("R9");
    endtask

    task automatic t_palette();
        put(8'h40, 3'd0, 2'd0, 1, 8'd0, 0, 0);
        put(8'hFF, 3'd1, 2'd0, 1, 8'd8, 0, 0);
        cfg(6'h01, 8'hEE);
        cfg(6'h00, 8'hDD);
        scan_line("R12");
        cfg(6'h20, 8'h99);
        cfg(6'h24, 8'h77);
        put(8'h80, 3'd1, 2'd2, 1, 8'd3, 0, 0);
        scan_line("R10");
    endtask

    task automatic t_clear();
        put(8'hFF, 3'd4, 2'd2, 1, 8'd150, 0, 0);
        scan_line("R11");
        scan_line("R11");
        scan_line("R11");
    endtask

    task automatic t_double_bank();
        put(8'hE4, 3'd2, 2'd0, 1, 8'd12, 0, 0);
        fork
            scan_line("R13");
            begin
                repeat (3) @(negedge clk);
                put(8'hFF, 3'd7, 2'd2, 1, 8'd12, 0, 0);
                put(8'h3C, 3'd5, 2'd0, 1, 8'd90, 0, 0);
            end
        join
        scan_line("R13");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mline[i] = 0;
        for (int i = 0; i < 32; i++) mpal[i] = 0;
        mpos = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_init_palette();
        t_wide4();
        t_split2();
        t_fine8();
        t_fine4();
        t_transparent();
        t_override();
        t_skip();
        t_wrap();
        t_palette();
        t_clear();
        t_double_bank();
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule